// File: doc/BRIEF.md
# Counted-Assertion Interrupt Delivery Engine

This block is the delivery half of a redirection-style interrupt controller. Every input pin owns a small signed counter. Sources change it with assert, deassert and pulse commands, so several sources can share one line. The engine looks at the pin's redirection image only when the count climbs from zero to one. It then decides whether an interrupt message goes out, and it builds that message from the image: vector, delivery mode, destination mode, trigger kind and a 15-bit destination.

For level-triggered pins the engine owns a remote-pending flag per pin. The flag blocks further deliveries until an end-of-interrupt notice with the matching vector arrives. The flag is also dropped when the entry is rewritten as edge-triggered. When a level pin is still held asserted after such a notice, or after its entry is rewritten, the engine sends again. Attempts queue as one pending bit per pin. They are served lowest pin first, one message per cycle, over a valid/ready output. The redirection images themselves are kept by a register file outside this block, which also announces each entry write.

Top module: `irq_delivery_engine`

## Requirements
- R1: Each pin's count starts at 0 and is 8-bit signed. The command codes are 0 assert (+1, saturating at +127), 1 deassert (−1, saturating at −128), 2 pulse (count unchanged) and 3 reserved (count unchanged, never an attempt).
- R2: A delivery attempt is raised only by an assert, or by a pulse, on a pin whose count is 0 at that moment. Every other count change raises nothing.
- R3: `cnt_neg` is high for one cycle, in the cycle after an accepted command, exactly when that pin's resulting count is negative.
- R4: A command whose 6-bit pin number is NUM_PINS or above raises `cmd_err` in the next cycle. It changes no count and causes no message.
- R5: An attempt on a pin whose image has the mask bit (bit 13) set produces no message.
- R6: For a level pin (image bit 12 = 1), an attempt is dropped while its remote-pending flag is set. Otherwise the flag is set and the message is sent. Edge pins (bit 12 = 0) never set the flag.
- R7: A message carries vector = image[7:0], mode = image[10:8], logical = image[11], level = image[12] and dest = {image[28:22], image[21:14]}, so the extension bits form dest[14:8].
- R8: An end-of-interrupt notice with vector V clears the remote-pending flag of every pin whose flag is set and whose vector equals V. Each such pin whose count is still positive gets a new attempt.
- R9: After an entry write, a level pin with a positive count gets a new attempt, and a pin written as edge-triggered has its remote-pending flag cleared.
- R10: Pending attempts are served in ascending pin order, one per cycle. A message appears on the second clock edge after the command that caused it. It is held stable while `msg_ready` is low.
- R11: During and right after reset, no message is valid, no flag is set and no attempt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Pin command strobe |
| cmd_pin | input | 6 | Pin number of the command (values ≥ NUM_PINS are rejected) |
| cmd_op | input | 2 | 0 assert, 1 deassert, 2 pulse, 3 reserved |
| cmd_err | output | 1 | Rejected pin number, one cycle after the command |
| cnt_neg | output | 1 | Count went or stayed below zero, one cycle after the command |
| ent_flat | input | NUM_PINS*29 | Current 29-bit redirection image of every pin, pin p at [p*29 +: 29] |
| ent_wr | input | 1 | Entry of `ent_wr_pin` was just rewritten (image already updated) |
| ent_wr_pin | input | 5 | Pin whose entry was written |
| eoi_valid | input | 1 | End-of-interrupt notice strobe |
| eoi_vector | input | 8 | Vector carried by the notice |
| msg_valid | output | 1 | Message available |
| msg_ready | input | 1 | Consumer takes the message |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Delivery mode |
| msg_logical | output | 1 | 1 logical, 0 physical destination |
| msg_level | output | 1 | 1 level-triggered source |
| msg_dest | output | 15 | Destination ID |

## Verification
The bench builds the engine with its defaults: 32 pins and 8-bit counts. That configuration lets it sweep every pin with its own vector, mode and destination pattern. It also makes the saturation limit reachable in 130 commands and lets the 6-bit pin field carry out-of-range numbers from 32 to 63. Expected messages are computed from the image fields in the bench and compared in arrival order. This exposes ordering, coalescing and the level-pin blocking and re-sending after end-of-interrupt notices and entry rewrites.

// File: rtl/irq_eng_pkg.sv
package irq_eng_pkg;

    localparam int IMG_W  = 29;
    localparam int VEC_W  = 8;
    localparam int DEST_W = 15;

    typedef enum logic [1:0] {
        OP_RAISE = 2'd0,
        OP_DROP  = 2'd1,
        OP_PULSE = 2'd2,
        OP_NONE  = 2'd3
    } pin_op_e;

    typedef struct packed {
        logic [VEC_W-1:0]  vector;
        logic [2:0]        mode;
        logic              logical;
        logic              level;
        logic [DEST_W-1:0] dest;
    } irq_msg_t;

    typedef struct packed {
        logic     masked;
        irq_msg_t msg;
    } img_view_t;

    // Image layout: [7:0] vector, [10:8] mode, [11] logical,
    // [12] level, [13] mask, [21:14] dest low, [28:22] dest extension.
    function automatic img_view_t unpack_img(input logic [IMG_W-1:0] img);
        img_view_t v;
        v.msg.vector  = img[7:0];
        v.msg.mode    = img[10:8];
        v.msg.logical = img[11];
        v.msg.level   = img[12];
        v.masked      = img[13];
        v.msg.dest    = {img[28:22], img[21:14]};
        return v;
    endfunction

endpackage

// File: rtl/irq_cnt_bank.sv
module irq_cnt_bank
    import irq_eng_pkg::*;
#(
    parameter int NUM_PINS = 32,
    parameter int CNT_W    = 8,
    localparam int PIN_W   = $clog2(NUM_PINS)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [PIN_W-1:0]    pin,
    input  logic [1:0]          op,
    output logic                rise,
    output logic                neg_q,
    output logic [NUM_PINS-1:0] positive
);

    localparam logic signed [CNT_W-1:0] CNT_TOP = {1'b0, {(CNT_W-1){1'b1}}};
    localparam logic signed [CNT_W-1:0] CNT_BOT = {1'b1, {(CNT_W-1){1'b0}}};

    logic signed [CNT_W-1:0] cnt_q [NUM_PINS];
    logic signed [CNT_W-1:0] cur;
    logic signed [CNT_W-1:0] nxt;

    assign cur = cnt_q[pin];

    always_comb begin
        nxt = cur;
        unique case (pin_op_e'(op))
            OP_RAISE: if (cur != CNT_TOP) nxt = cur + CNT_W'(1);
            OP_DROP:  if (cur != CNT_BOT) nxt = cur - CNT_W'(1);
            default:  nxt = cur;
        endcase
    end

    assign rise = go && (cur == '0) &&
                  ((pin_op_e'(op) == OP_RAISE) || (pin_op_e'(op) == OP_PULSE));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_PINS; i++) cnt_q[i] <= '0;
            neg_q <= 1'b0;
        end else begin
            neg_q <= go && nxt[CNT_W-1];
            if (go) cnt_q[pin] <= nxt;
        end
    end

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_pos
        assign positive[g] = !cnt_q[g][CNT_W-1] && (cnt_q[g] != '0);
    end

endmodule

// File: rtl/irq_pick_lowest.sv
module irq_pick_lowest #(
    parameter int N      = 32,
    localparam int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/irq_delivery_engine.sv
module irq_delivery_engine
    import irq_eng_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    parameter int CNT_W      = 8,
    localparam int PIN_W     = $clog2(NUM_PINS),
    localparam int CMD_PIN_W = PIN_W + 1
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      cmd_valid,
    input  logic [CMD_PIN_W-1:0]      cmd_pin,
    input  logic [1:0]                cmd_op,
    output logic                      cmd_err,
    output logic                      cnt_neg,
    input  logic [NUM_PINS*IMG_W-1:0] ent_flat,
    input  logic                      ent_wr,
    input  logic [PIN_W-1:0]          ent_wr_pin,
    input  logic                      eoi_valid,
    input  logic [VEC_W-1:0]          eoi_vector,
    output logic                      msg_valid,
    input  logic                      msg_ready,
    output logic [VEC_W-1:0]          msg_vector,
    output logic [2:0]                msg_mode,
    output logic                      msg_logical,
    output logic                      msg_level,
    output logic [DEST_W-1:0]         msg_dest
);

    localparam logic [CMD_PIN_W-1:0] PIN_LIMIT = CMD_PIN_W'(NUM_PINS);

    img_view_t           view [NUM_PINS];
    logic                pin_ok, cmd_go, cnt_rise;
    logic [PIN_W-1:0]    cmd_idx;
    logic [NUM_PINS-1:0] cnt_pos;
    logic [NUM_PINS-1:0] pending_q, irr_q;
    logic [NUM_PINS-1:0] pend_set, irr_clr, eoi_hit, svc_onehot;
    logic                pick_found, can_load, svc_go, svc_deliver;
    logic [PIN_W-1:0]    pick_idx;
    img_view_t           svc_view;
    logic                msg_valid_q, cmd_err_q;
    irq_msg_t            msg_q;

    for (genvar g = 0; g < NUM_PINS; g++) begin : g_view
        assign view[g]    = unpack_img(ent_flat[g*IMG_W +: IMG_W]);
        assign eoi_hit[g] = eoi_valid && irr_q[g] && (view[g].msg.vector == eoi_vector);
    end

    assign pin_ok  = cmd_pin < PIN_LIMIT;
    assign cmd_go  = cmd_valid && pin_ok;
    assign cmd_idx = cmd_pin[PIN_W-1:0];

    irq_cnt_bank #(.NUM_PINS(NUM_PINS), .CNT_W(CNT_W)) i_cnt (
        .clk      (clk),
        .rst      (rst),
        .go       (cmd_go),
        .pin      (cmd_idx),
        .op       (cmd_op),
        .rise     (cnt_rise),
        .neg_q    (cnt_neg),
        .positive (cnt_pos)
    );

    // Attempt sources: count rise, notice re-send, entry rewrite.
    always_comb begin
        pend_set = eoi_hit & cnt_pos;
        irr_clr  = eoi_hit;
        if (cnt_rise) pend_set[cmd_idx] = 1'b1;
        if (ent_wr) begin
            if (view[ent_wr_pin].msg.level) begin
                if (cnt_pos[ent_wr_pin]) pend_set[ent_wr_pin] = 1'b1;
            end else begin
                irr_clr[ent_wr_pin] = 1'b1;
            end
        end
    end

    irq_pick_lowest #(.N(NUM_PINS)) i_pick (
        .req   (pending_q),
        .found (pick_found),
        .idx   (pick_idx)
    );

    assign can_load    = !msg_valid_q || msg_ready;
    assign svc_go      = pick_found && can_load;
    assign svc_view    = view[pick_idx];
    assign svc_deliver = svc_go && !svc_view.masked &&
                         !(svc_view.msg.level && irr_q[pick_idx]);

    always_comb begin
        svc_onehot = '0;
        if (svc_go) svc_onehot[pick_idx] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pending_q   <= '0;
            irr_q       <= '0;
            msg_valid_q <= 1'b0;
            msg_q       <= '0;
            cmd_err_q   <= 1'b0;
        end else begin
            pending_q <= (pending_q & ~svc_onehot) | pend_set;
            irr_q     <= (irr_q & ~irr_clr) |
                         ((svc_deliver && svc_view.msg.level) ? svc_onehot : '0);
            cmd_err_q <= cmd_valid && !pin_ok;
            if (svc_deliver) begin
                msg_valid_q <= 1'b1;
                msg_q       <= svc_view.msg;
            end else if (msg_ready) begin
                msg_valid_q <= 1'b0;
            end
        end
    end

    assign cmd_err     = cmd_err_q;
    assign msg_valid   = msg_valid_q;
    assign msg_vector  = msg_q.vector;
    assign msg_mode    = msg_q.mode;
    assign msg_logical = msg_q.logical;
    assign msg_level   = msg_q.level;
    assign msg_dest    = msg_q.dest;

endmodule

// File: rtl/irq_engine_checker.sv
module irq_engine_checker
    import irq_eng_pkg::*;
#(
    parameter int NUM_PINS   = 32,
    localparam int PIN_W     = $clog2(NUM_PINS),
    localparam int CMD_PIN_W = PIN_W + 1
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 cmd_valid,
    input logic [CMD_PIN_W-1:0] cmd_pin,
    input logic                 cmd_err,
    input logic                 msg_valid,
    input logic                 msg_ready,
    input irq_msg_t             msg_word,
    input logic                 svc_deliver,
    input logic                 svc_level,
    input logic [PIN_W-1:0]     svc_pin,
    input logic [NUM_PINS-1:0]  irr_q
);

    localparam logic [CMD_PIN_W-1:0] PIN_LIMIT = CMD_PIN_W'(NUM_PINS);

    a_r10_hold_stable: assert property (@(posedge clk) disable iff (rst)
        msg_valid && !msg_ready |=> msg_valid && $stable(msg_word));

    a_r4_reject_high: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && (cmd_pin >= PIN_LIMIT) |=> cmd_err);

    a_r4_accept_low: assert property (@(posedge clk) disable iff (rst)
        !(cmd_valid && (cmd_pin >= PIN_LIMIT)) |=> !cmd_err);

    a_r6_flag_on_send: assert property (@(posedge clk) disable iff (rst)
        svc_deliver && svc_level |=> irr_q[$past(svc_pin)]);

    a_r11_reset_idle: assert property (@(posedge clk)
        rst |=> !msg_valid && (irr_q == '0));

endmodule

bind irq_delivery_engine irq_engine_checker #(.NUM_PINS(NUM_PINS)) i_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .cmd_pin     (cmd_pin),
    .cmd_err     (cmd_err),
    .msg_valid   (msg_valid),
    .msg_ready   (msg_ready),
    .msg_word    (msg_q),
    .svc_deliver (svc_deliver),
    .svc_level   (svc_view.msg.level),
    .svc_pin     (pick_idx),
    .irr_q       (irr_q)
);

// File: tb/test_irq_delivery_engine.sv
module test_irq_delivery_engine;

    localparam int NP = 32;
    localparam int IW = 29;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cmd_valid = 1'b0;
    logic [5:0]     cmd_pin = '0;
    logic [1:0]     cmd_op = '0;
    logic           cmd_err, cnt_neg;
    logic [NP*IW-1:0] ent_flat;
    logic           ent_wr = 1'b0;
    logic [4:0]     ent_wr_pin = '0;
    logic           eoi_valid = 1'b0;
    logic [7:0]     eoi_vector = '0;
    logic           msg_valid;
    logic           msg_ready = 1'b1;
    logic [7:0]     msg_vector;
    logic [2:0]     msg_mode;
    logic           msg_logical, msg_level;
    logic [14:0]    msg_dest;

    logic [IW-1:0]  img_tab [NP];
    logic [27:0]    got_q [64];
    logic [27:0]    exp_q [64];
    int             got_n = 0, exp_n = 0;
    int             neg_seen = 0, err_seen = 0;
    int             checks = 0, fails = 0;
    bit             done = 1'b0;

    always #4 clk = ~clk;

    always_comb begin
        for (int p = 0; p < NP; p++) ent_flat[p*IW +: IW] = img_tab[p];
    end

    irq_delivery_engine i_irq_delivery_engine (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_pin(cmd_pin), .cmd_op(cmd_op),
        .cmd_err(cmd_err), .cnt_neg(cnt_neg),
        .ent_flat(ent_flat), .ent_wr(ent_wr), .ent_wr_pin(ent_wr_pin),
        .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
        .msg_valid(msg_valid), .msg_ready(msg_ready),
        .msg_vector(msg_vector), .msg_mode(msg_mode),
        .msg_logical(msg_logical), .msg_level(msg_level), .msg_dest(msg_dest)
    );

    wire [27:0] msg_word = {msg_vector, msg_mode, msg_logical, msg_level, msg_dest};

    always @(negedge clk) begin
        if (!rst) begin
            if (msg_valid && msg_ready && got_n < 64) begin
                got_q[got_n] = msg_word;
                got_n++;
            end
            if (cnt_neg) neg_seen++;
            if (cmd_err) err_seen++;
        end
    end

    function automatic logic [IW-1:0] mk(input logic [7:0] vec, input logic [2:0] mode,
                                         input logic lg, input logic lv, input logic mk_b,
                                         input logic [7:0] dlo, input logic [6:0] dext);
        return {dext, dlo, mk_b, lv, lg, mode, vec};
    endfunction

    // Expected message from an image, per the field positions of R7.
    function automatic logic [27:0] exp_of(input logic [IW-1:0] img);
        return {img[7:0], img[10:8], img[11], img[12], img[28:22], img[21:14]};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] got_v, input logic [63:0] exp_v);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got_v, exp_v);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic settle(input int n);
        repeat (n) tick();
    endtask

    task automatic do_cmd(input int pin, input int op);
        cmd_valid = 1'b1;
        cmd_pin   = 6'(pin);
        cmd_op    = 2'(op);
        tick();
        cmd_valid = 1'b0;
    endtask

    task automatic wr_entry(input int pin, input logic [IW-1:0] img);
        img_tab[pin] = img;
        ent_wr       = 1'b1;
        ent_wr_pin   = 5'(pin);
        tick();
        ent_wr = 1'b0;
    endtask

    task automatic eoi(input logic [7:0] v);
        eoi_valid  = 1'b1;
        eoi_vector = v;
        tick();
        eoi_valid = 1'b0;
    endtask

    task automatic push_exp(input logic [IW-1:0] img);
        exp_q[exp_n] = exp_of(img);
        exp_n++;
    endtask

    task automatic compare(input string req);
        settle(6);
        chk(got_n == exp_n, req, "message count", 64'(got_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(got_q[i] == exp_q[i], req, "message content", 64'(got_q[i]), 64'(exp_q[i]));
        got_n = 0;
        exp_n = 0;
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < NP; p++) img_tab[p] = mk(8'h00, 3'd0, 1'b0, 1'b0, 1'b1, 8'h00, 7'h00);
        settle(3);
        rst = 1'b0;
        #0;
        @(negedge clk);
        // R11: idle after reset
        chk(msg_valid == 1'b0, "R11", "msg_valid after reset", 64'(msg_valid), 0);
        chk(cmd_err == 1'b0 && cnt_neg == 1'b0, "R11", "flags after reset", 64'({cmd_err, cnt_neg}), 0);
        tick();

        // R10 latency: message on the second edge after the command
        img_tab[0] = mk(8'h40, 3'd1, 1'b1, 1'b0, 1'b0, 8'h12, 7'h3);
        do_cmd(0, 0);
        @(negedge clk);
        chk(msg_valid == 1'b0, "R10", "valid one edge after command", 64'(msg_valid), 0);
        @(negedge clk);
        chk(msg_valid == 1'b1, "R10", "valid two edges after command", 64'(msg_valid), 1);
        push_exp(img_tab[0]);
        compare("R10");
        do_cmd(0, 1);

        // R2/R7: sweep all pins, edge, unmasked, varied fields
        for (int p = 0; p < NP; p++)
            img_tab[p] = mk(8'(8'h40 + p), 3'(p % 8), p[0], 1'b0, 1'b0,
                            8'(p * 7 + 1), 7'(p ^ 7'h55));
        for (int p = 0; p < NP; p++) begin
            do_cmd(p, 0);
            push_exp(img_tab[p]);
            do_cmd(p, 0);
        end
        compare("R7");
        for (int p = 0; p < NP; p++) begin
            do_cmd(p, 1);
            do_cmd(p, 1);
        end
        compare("R2");
        chk(neg_seen == 0, "R3", "no negative flag at zero", 64'(neg_seen), 0);

        // R3: negative count flag
        do_cmd(3, 1);
        @(negedge clk);
        chk(cnt_neg == 1'b1, "R3", "flag on count -1", 64'(cnt_neg), 1);
        tick();
        do_cmd(3, 0);
        @(negedge clk);
        chk(cnt_neg == 1'b0, "R3", "no flag at 0", 64'(cnt_neg), 0);
        tick();
        compare("R2");
        do_cmd(3, 0);
        push_exp(img_tab[3]);
        compare("R2");
        do_cmd(3, 1);

        // R1: saturation at +127
        for (int k = 0; k < 130; k++) do_cmd(5, 0);
        push_exp(img_tab[5]);
        for (int k = 0; k < 127; k++) do_cmd(5, 1);
        do_cmd(5, 0);
        push_exp(img_tab[5]);
        compare("R1");
        do_cmd(5, 1);

        // R1: pulse keeps count, reserved op does nothing
        do_cmd(6, 2);
        push_exp(img_tab[6]);
        do_cmd(6, 2);
        push_exp(img_tab[6]);
        do_cmd(6, 3);
        settle(3);
        do_cmd(6, 0);
        push_exp(img_tab[6]);
        compare("R1");
        do_cmd(6, 1);

        // R5: masked pin sends nothing
        img_tab[8] = mk(8'h77, 3'd0, 1'b0, 1'b0, 1'b1, 8'h08, 7'h0);
        do_cmd(8, 0);
        compare("R5");
        do_cmd(8, 1);

        // R6/R8: level pin blocking and re-send after notice
        img_tab[10] = mk(8'h91, 3'd2, 1'b0, 1'b1, 1'b0, 8'hA0, 7'h11);
        do_cmd(10, 0);
        push_exp(img_tab[10]);
        compare("R6");
        do_cmd(10, 1);
        do_cmd(10, 0);
        compare("R6");
        eoi(8'h92);
        compare("R8");
        eoi(8'h91);
        push_exp(img_tab[10]);
        compare("R8");
        do_cmd(10, 1);
        eoi(8'h91);
        compare("R8");
        do_cmd(10, 0);
        push_exp(img_tab[10]);
        compare("R6");
        do_cmd(10, 1);
        eoi(8'h91);

        // R9: entry rewrites
        img_tab[12] = mk(8'h5C, 3'd4, 1'b1, 1'b1, 1'b1, 8'h0C, 7'h2);
        do_cmd(12, 0);
        compare("R5");
        wr_entry(12, mk(8'h5C, 3'd4, 1'b1, 1'b1, 1'b0, 8'h0C, 7'h2));
        push_exp(img_tab[12]);
        compare("R9");
        wr_entry(12, img_tab[12]);
        compare("R9");
        wr_entry(12, mk(8'h5C, 3'd4, 1'b1, 1'b0, 1'b0, 8'h0C, 7'h2));
        compare("R9");
        wr_entry(12, mk(8'h5C, 3'd4, 1'b1, 1'b1, 1'b0, 8'h0C, 7'h2));
        push_exp(img_tab[12]);
        compare("R9");
        do_cmd(12, 1);
        eoi(8'h5C);

        // R10: ascending order and hold under back-pressure
        img_tab[17] = mk(8'hA5, 3'd0, 1'b0, 1'b1, 1'b0, 8'd17, 7'h01);
        img_tab[20] = mk(8'hA5, 3'd1, 1'b0, 1'b1, 1'b0, 8'd20, 7'h02);
        img_tab[25] = mk(8'hA5, 3'd2, 1'b1, 1'b1, 1'b0, 8'd25, 7'h03);
        img_tab[30] = mk(8'hA5, 3'd3, 1'b1, 1'b1, 1'b0, 8'd30, 7'h04);
        do_cmd(25, 0); push_exp(img_tab[25]);
        do_cmd(17, 0); push_exp(img_tab[17]);
        do_cmd(30, 0); push_exp(img_tab[30]);
        do_cmd(20, 0); push_exp(img_tab[20]);
        compare("R6");
        msg_ready = 1'b0;
        eoi(8'hA5);
        tick();
        @(negedge clk);
        chk(msg_valid == 1'b1, "R10", "valid under back-pressure", 64'(msg_valid), 1);
        chk(msg_word == exp_of(img_tab[17]), "R10", "lowest pin first",
            64'(msg_word), 64'(exp_of(img_tab[17])));
        settle(4);
        @(negedge clk);
        chk(msg_valid == 1'b1 && msg_word == exp_of(img_tab[17]), "R10", "held while not ready",
            64'(msg_word), 64'(exp_of(img_tab[17])));
        tick();
        msg_ready = 1'b1;
        push_exp(img_tab[17]);
        push_exp(img_tab[20]);
        push_exp(img_tab[25]);
        push_exp(img_tab[30]);
        compare("R10");
        do_cmd(17, 1); do_cmd(20, 1); do_cmd(25, 1); do_cmd(30, 1);
        eoi(8'hA5);
        compare("R8");

        // R4: out-of-range pin numbers
        err_seen = 0;
        do_cmd(32, 0);
        @(negedge clk);
        chk(cmd_err == 1'b1, "R4", "error for pin 32", 64'(cmd_err), 1);
        tick();
        do_cmd(40, 2);
        do_cmd(63, 0);
        do_cmd(0, 1);
        @(negedge clk);
        chk(cnt_neg == 1'b1, "R4", "pin 0 count untouched (deassert gives -1)", 64'(cnt_neg), 1);
        tick();
        chk(err_seen == 3, "R4", "error pulses", 64'(err_seen), 3);
        compare("R4");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule